// File: doc/BRIEF.md
# FIFO Read-Side Replay Controller

This block is a single-clock first-in first-out buffer. Its read side can rewind to storage location zero, so a consumer can take the stored stream again, as many times as it needs. The write side is a plain pointer with a full guard. The read side has a registered data output and holds all of the rewind logic. The word count and the empty flag always come from the difference between the write and read pointers, so they follow a rewind at once.

A replay request is an active-low pin sampled on the rising clock edge. A mode pin is captured while master reset is held and chooses between two replay timings. In the immediate timing, the output register takes word zero on the very edge that sampled the request, and the next read returns word one. In the deferred timing, the read pointer moves to zero and the output register keeps its old value until the next accepted read, which returns word zero. Replay is meant for streams of at most `DEPTH` words written since master reset.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: While `mrst_n` is low and on the first edge after it rises, `empty` is 1, `level` is 0 and `rd_data` is 0.
- R2: Words are read in write order. A read is accepted when `rd_en` is high and `empty` is low, and the word appears on `rd_data` after the rising edge that accepted it.
- R3: `rt_n` low on a rising edge, after at least one word has been written since reset, moves the read pointer back to storage location 0. Later reads then return the stream from its first word.
- R4: The replay timing is taken from `lat_mode` only while `mrst_n` is low: 0 selects immediate and 1 selects deferred. A change of `lat_mode` after reset has no effect.
- R5: In immediate timing, `rd_data` shows word 0 right after the edge that sampled `rt_n` low, and the next accepted read returns word 1.
- R6: In deferred timing, `rd_data` keeps its previous value across the replay edge, and the next accepted read returns word 0.
- R7: After a replay, `level` equals the number of words written since reset, minus 1 in immediate timing. `empty` is 1 exactly when `level` is 0.
- R8: `rt_n` low before any word has been written since reset has no effect: `level` stays 0, `empty` stays 1 and `rd_data` is unchanged.
- R9: When `rt_n` is low and `rd_en` is high on the same edge, the replay is carried out and the read is discarded.
- R10: Replays may be repeated. Each one restarts the stream from word 0.
- R11: A write while `level` equals `DEPTH` is dropped. A read while `empty` is 1 leaves `rd_data` and `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, active low, synchronous; captures `lat_mode` |
| lat_mode | input | 1 | Replay timing select, sampled during reset: 0 immediate, 1 deferred |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Replay request, active low |
| rd_data | output | DATA_W | Registered read data |
| empty | output | 1 | No unread words |
| full | output | 1 | Level equals DEPTH |
| level | output | clog2(DEPTH)+1 | Count of unread words |

## Verification
The bench sweeps both timings and every stream length from 1 to `DEPTH`, with part of each stream read before the replay. A design that loads word zero one edge late in immediate timing shows the previous word on `rd_data` instead. A deferred design that refreshes the output register on the replay edge shows a word that was never read. A design that lets a simultaneous read advance past the rewind skips word zero or word one. A design that skips the level recomputation reports `empty` over a full stream. The bench also issues a replay before any write, to catch a design that rewinds into unwritten storage. It writes into a full buffer and reads from an empty one to expose a broken guard. It flips `lat_mode` after reset to catch a design that samples the pin at all times.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
   typedef enum logic {
      RT_IMMEDIATE = 1'b0,
      RT_DEFERRED  = 1'b1
   } rt_timing_e;
endpackage

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DATA_W-1:0]        rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr #(
   parameter int DEPTH = 8
) (
   input  logic                   clk,
   input  logic                   mrst_n,
   input  logic                   wr_en,
   input  logic                   full,
   output logic                   wr_go,
   output logic [$clog2(DEPTH):0] wr_ptr,
   output logic                   any_written
);
   assign wr_go = wr_en && !full;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         wr_ptr      <= '0;
         any_written <= 1'b0;
      end else if (wr_go) begin
         wr_ptr      <= wr_ptr + 1'b1;
         any_written <= 1'b1;
      end
   end

   AST_WRITE_BLOCKED_FULL: assert property (@(posedge clk) disable iff (!mrst_n)
      (wr_en && full) |=> $stable(wr_ptr)) else $error("write into full buffer"); // R11
endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd
   import fifo_rt_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     mrst_n,
   input  logic                     lat_mode,
   input  logic                     rd_en,
   input  logic                     rt_n,
   input  logic                     any_written,
   input  logic                     empty,
   input  logic [DATA_W-1:0]        mem_q,
   output logic [$clog2(DEPTH)-1:0] mem_addr,
   output logic [$clog2(DEPTH):0]   rd_ptr,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int AW = $clog2(DEPTH);

   rt_timing_e timing_q;
   logic       rt_hit;
   logic       rd_go;

   assign rt_hit   = !rt_n && any_written;
   assign rd_go    = rd_en && !empty && !rt_hit;
   assign mem_addr = (rt_hit && timing_q == RT_IMMEDIATE) ? '0 : rd_ptr[AW-1:0];

   always_ff @(posedge clk) begin
      if (!mrst_n) timing_q <= rt_timing_e'(lat_mode);
   end

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         rd_ptr  <= '0;
         rd_data <= '0;
      end else if (rt_hit) begin
         if (timing_q == RT_IMMEDIATE) begin
            rd_ptr  <= {{AW{1'b0}}, 1'b1};
            rd_data <= mem_q;
         end else begin
            rd_ptr  <= '0;
         end
      end else if (rd_go) begin
         rd_ptr  <= rd_ptr + 1'b1;
         rd_data <= mem_q;
      end
   end

   AST_REWIND_DEFERRED: assert property (@(posedge clk) disable iff (!mrst_n)
      (rt_hit && timing_q == RT_DEFERRED) |=> rd_ptr == '0) else $error("deferred rewind"); // R3
   AST_REWIND_IMMEDIATE: assert property (@(posedge clk) disable iff (!mrst_n)
      (rt_hit && timing_q == RT_IMMEDIATE) |=> rd_ptr == 1) else $error("immediate rewind"); // R5
   AST_DEFERRED_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
      (rt_hit && timing_q == RT_DEFERRED) |=> $stable(rd_data)) else $error("deferred output moved"); // R6
   AST_RT_UNWRITTEN: assert property (@(posedge clk) disable iff (!mrst_n)
      (!rt_n && !any_written) |=> ($stable(rd_ptr) && $stable(rd_data))) else $error("replay of empty store"); // R8
   AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (!mrst_n)
      $past(mrst_n) |-> $stable(timing_q)) else $error("timing changed after reset"); // R4
   AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!mrst_n)
      (rd_en && empty && rt_n) |=> $stable(rd_data)) else $error("read while empty"); // R11
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   mrst_n,
   input  logic                   lat_mode,
   input  logic                   wr_en,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   rd_en,
   input  logic                   rt_n,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   empty,
   output logic                   full,
   output logic [$clog2(DEPTH):0] level
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic          wr_go;
   logic [AW:0]   wr_ptr;
   logic [AW:0]   rd_ptr;
   logic          any_written;
   logic [AW-1:0] mem_addr;
   logic [DATA_W-1:0] mem_q;

   assign level = wr_ptr - rd_ptr;
   assign empty = (level == '0);
   assign full  = (level == DEPTH[AW:0]);

   fifo_rt_wr #(.DEPTH(DEPTH)) u_wr (
      .clk(clk), .mrst_n(mrst_n), .wr_en(wr_en), .full(full),
      .wr_go(wr_go), .wr_ptr(wr_ptr), .any_written(any_written)
   );

   fifo_rt_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .we(wr_go), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
      .raddr(mem_addr), .rdata(mem_q)
   );

   fifo_rt_rd #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rd (
      .clk(clk), .mrst_n(mrst_n), .lat_mode(lat_mode), .rd_en(rd_en), .rt_n(rt_n),
      .any_written(any_written), .empty(empty), .mem_q(mem_q),
      .mem_addr(mem_addr), .rd_ptr(rd_ptr), .rd_data(rd_data)
   );

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
      level <= DEPTH) else $error("level above depth"); // R11
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !mrst_n |=> (level == '0 && rd_data == '0)) else $error("reset state"); // R1
endmodule

// File: tb/sim_fifo_rt_ctrl.sv
module sim_fifo_rt_ctrl;
   localparam int DEPTH  = 8;
   localparam int DATA_W = 8;
   localparam int AW     = $clog2(DEPTH);

   logic clk = 1'b0;
   logic mrst_n = 1'b0, lat_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic empty, full;
   logic [AW:0] level;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   fifo_rt_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
      .clk(clk), .mrst_n(mrst_n), .lat_mode(lat_mode), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rt_n(rt_n), .rd_data(rd_data), .empty(empty), .full(full), .level(level)
   );

   function automatic logic [DATA_W-1:0] word(int m, int n, int i);
      return DATA_W'((i * 37 + n * 5 + m * 101 + 1) & 8'hFF);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset(int m);
      lat_mode = m[0];
      mrst_n = 1'b0;
      tick();
      check("R1 empty in reset", empty, 1);
      tick();
      mrst_n = 1'b1;
      lat_mode = ~m[0];
      tick();
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #3;
      for (int m = 0; m < 2; m++) begin
         for (int n = 1; n <= DEPTH; n++) begin
            int k;
            int exp_lvl;
            logic [DATA_W-1:0] last;
            do_reset(m);
            check("R1 empty", empty, 1);
            check("R1 level", level, 0);
            check("R1 rd_data", rd_data, 0);
            // R8: replay before any write
            rt_n = 1'b0; tick(); rt_n = 1'b1;
            check("R8 level", level, 0);
            check("R8 empty", empty, 1);
            check("R8 rd_data", rd_data, 0);
            for (int i = 0; i < n; i++) begin
               wr_en = 1'b1; wr_data = word(m, n, i); tick();
            end
            wr_en = 1'b0;
            check("R2 level after writes", level, n);
            if (n == DEPTH) begin
               check("R11 full", full, 1);
               wr_en = 1'b1; wr_data = 8'hEE; tick(); wr_en = 1'b0;
               check("R11 write dropped", level, DEPTH);
            end
            k = n / 2;
            last = '0;
            for (int i = 0; i < k; i++) begin
               rd_en = 1'b1; tick();
               check("R2 read order", rd_data, word(m, n, i));
               last = word(m, n, i);
            end
            rd_en = 1'b0;
            // replay, with a simultaneous read on odd lengths (R9)
            rt_n = 1'b0; rd_en = n[0]; tick(); rt_n = 1'b1; rd_en = 1'b0;
            exp_lvl = (m == 0) ? n - 1 : n;
            if (m == 0) check("R5 R9 word0 on replay edge", rd_data, word(m, n, 0));
            else        check("R6 R9 output held", rd_data, last);
            check("R7 R9 level after replay", level, exp_lvl);
            check("R7 empty after replay", empty, exp_lvl == 0);
            for (int i = (m == 0) ? 1 : 0; i < n; i++) begin
               rd_en = 1'b1; tick();
               check("R3 replayed stream", rd_data, word(m, n, i));
            end
            rd_en = 1'b0;
            check("R7 drained", empty, 1);
            rd_en = 1'b1; tick(); rd_en = 1'b0;
            check("R11 read while empty", rd_data, word(m, n, n - 1));
            check("R11 level stays", level, 0);
            // second replay (R10)
            rt_n = 1'b0; tick(); rt_n = 1'b1;
            check("R10 level again", level, exp_lvl);
            if (m == 0) check("R10 word0 again", rd_data, word(m, n, 0));
            rd_en = 1'b1; tick(); rd_en = 1'b0;
            if (m == 1)      check("R10 R4 first read word0", rd_data, word(m, n, 0));
            else if (n > 1)  check("R10 R4 next read word1", rd_data, word(m, n, 1));
            else             check("R10 empty read holds", rd_data, word(m, n, 0));
         end
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule